// File: doc/BRIEF.md
# Processor-Port Memory Bank Decoder

This block sits between an 8-bit processor with a 16-bit address bus and the memories and peripherals around it. It contains the processor's two built-in port registers, a direction register at address $0000 and a value register at address $0001. From these it derives which read sources are visible in the 64 KiB space: a BASIC ROM, a KERNAL ROM, a character ROM, or an I/O area that holds video, sound, colour RAM, two timer chips and two expansion strobes.

For every access it raises exactly one chip select and a local register offset for the selected peripheral. Writes that fall into a ROM window land in the RAM underneath. The colour RAM is only four bits wide, so on a read the block fills the upper nibble with bits from an internal 16-bit LFSR. The memories themselves sit outside the block. The port registers are read back through the same read-data path as any other location.

Top module: `bank_decoder`

## Requirements
- R1: After reset both port registers hold 0, and reading address $0000 or $0001 returns 8'h00.
- R2: The effective port value is P = ~dir | val. A read in $A000-$BFFF selects BASIC ROM (chip_sel bit 1) when P[1:0] == 2'b11. Otherwise it selects RAM (bit 0).
- R3: A read in $E000-$FFFF selects KERNAL ROM (bit 2) when P[1] is 1. Otherwise it selects RAM.
- R4: For a read in $D000-$DFFF: if P[1:0] != 0 and P[2] is 1, the access goes to I/O. If P[1:0] != 0 and P[2] is 0, it selects character ROM (bit 3). If P[1:0] == 0, it selects RAM.
- R5: Within I/O, address bits 11:8 choose the device and reg_off gives its offset, zero-extended. Values 0-3 select video (bit 4, offset addr[5:0]). Values 4-7 select sound (bit 5, addr[4:0]). Values 8-B select colour RAM (bit 6, addr[9:0]). C selects timer 1 (bit 7, addr[3:0]). D selects timer 2 (bit 8, addr[3:0]). E selects expansion 1 (bit 9, addr[7:0]). F selects expansion 2 (bit 10, addr[7:0]). Every non-I/O select gives reg_off = 0.
- R6: A colour RAM read returns {noise[3:0], col_rdata}. On a colour RAM write, col_wdata equals acc_wdata[3:0].
- R7: The noise LFSR resets to 16'hACE1. It shifts left with feedback bit15^bit13^bit12^bit10 entering bit 0. It advances once per colour RAM read and holds otherwise.
- R8: A write never selects a ROM. Writes in the BASIC and KERNAL windows select RAM. A write in $D000-$DFFF selects RAM whenever I/O is not mapped, even when character ROM is mapped for reads.
- R9: A write to address $0000 loads the direction register and a write to $0001 loads the value register. The new mapping applies from the next cycle. Reads of $0000 and $0001 return the registers.
- R10: After any port write that leaves direction bit 4 at 0, value bit 4 reads back as 1.
- R11: When acc_valid is 1, exactly one chip_sel bit is set. When acc_valid is 0, chip_sel is all zero. A read that is not a port register and not colour RAM returns ext_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Access address |
| acc_wdata | input | 8 | Write data |
| ext_rdata | input | 8 | Read data from the selected external source |
| col_rdata | input | 4 | Nibble read from colour RAM |
| acc_rdata | output | 8 | Read data returned to the processor |
| chip_sel | output | 11 | One-hot select (bit order in R2-R5) |
| reg_off | output | 10 | Register offset inside the selected peripheral |
| col_wdata | output | 4 | Nibble written to colour RAM |

## Verification
Two functions can fall into back-to-back cycles. The first case is a write to the value register followed straight away by an access to a bank it switches. The bench reads $A000 and then writes $0001 with no idle cycle between them, then reads $A000 again. It expects the old select before the clock edge and the new select after it. The second case is a run of consecutive colour RAM reads, each of which both uses the noise nibble and advances it. The bench predicts every nibble from the LFSR polynomial. It also checks that a character ROM access placed between reads leaves the sequence unchanged.

// File: rtl/bank_pkg.sv
package bank_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int NIB_W   = 4;
    localparam int OFF_W   = 10;
    localparam int LFSR_W  = 16;
    localparam int NIO     = 7;
    localparam int NSEL    = 4 + NIO;

    localparam int SEL_RAM    = 0;
    localparam int SEL_BASIC  = 1;
    localparam int SEL_KERNAL = 2;
    localparam int SEL_CHAR   = 3;
    localparam int SEL_VIDEO  = 4;
    localparam int SEL_SOUND  = 5;
    localparam int SEL_COLOUR = 6;
    localparam int SEL_TMR1   = 7;
    localparam int SEL_TMR2   = 8;
    localparam int SEL_EXP1   = 9;
    localparam int SEL_EXP2   = 10;

    typedef struct packed {
        logic [DATA_W-1:0] dir;
        logic [DATA_W-1:0] val;
    } port_state_t;

    typedef struct packed {
        logic basic_vis;
        logic kernal_vis;
        logic char_vis;
        logic io_vis;
    } bank_map_t;
endpackage

// File: rtl/bank_port_regs.sv
module bank_port_regs
    import bank_pkg::*;
#(
    parameter int SENSE_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_dir,
    input  logic              wr_val,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dir_o,
    output logic [DATA_W-1:0] val_o,
    output logic [DATA_W-1:0] eff_o
);
    port_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_dir) st_d.dir = wdata;
        if (wr_val) st_d.val = wdata;
        // keep the tape-sense input pulled high while it is an input
        if ((wr_dir || wr_val) && !st_d.dir[SENSE_BIT])
            st_d.val[SENSE_BIT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_o = st_q.dir;
    assign val_o = st_q.val;
    assign eff_o = ~st_q.dir | st_q.val;
endmodule

// File: rtl/bank_window_map.sv
module bank_window_map
    import bank_pkg::*;
#(
    parameter int LO_BIT = 0,
    parameter int HI_BIT = 1,
    parameter int IO_BIT = 2
) (
    input  logic [DATA_W-1:0] eff,
    output bank_map_t         map
);
    logic any_low;

    always_comb begin
        any_low        = eff[LO_BIT] | eff[HI_BIT];
        map.basic_vis  = eff[LO_BIT] & eff[HI_BIT];
        map.kernal_vis = eff[HI_BIT];
        map.char_vis   = any_low & ~eff[IO_BIT];
        map.io_vis     = any_low &  eff[IO_BIT];
    end
endmodule

// File: rtl/bank_io_select.sv
module bank_io_select
    import bank_pkg::*;
(
    input  logic [11:0]      io_addr,
    output logic [NIO-1:0]   dev_hit,
    output logic [OFF_W-1:0] dev_off
);
    // device d owns nibble range [first..last] and an offset of width wid
    function automatic int dev_first(int d);
        case (d)
            0: return 0;   1: return 4;   2: return 8;
            3: return 12;  4: return 13;  5: return 14;
            default: return 15;
        endcase
    endfunction

    function automatic int dev_last(int d);
        case (d)
            0: return 3;   1: return 7;   2: return 11;
            3: return 12;  4: return 13;  5: return 14;
            default: return 15;
        endcase
    endfunction

    function automatic int dev_wid(int d);
        case (d)
            0: return 6;   1: return 5;   2: return 10;
            3: return 4;   4: return 4;
            default: return 8;
        endcase
    endfunction

    logic [3:0] nib;
    assign nib = io_addr[11:8];

    logic [OFF_W-1:0] masked [NIO];

    for (genvar d = 0; d < NIO; d++) begin : g_dev
        localparam int FIRST = dev_first(d);
        localparam int LAST  = dev_last(d);
        localparam int WID   = dev_wid(d);
        localparam logic [OFF_W-1:0] MASK = OFF_W'((1 << WID) - 1);
        assign dev_hit[d] = (32'(nib) >= FIRST) && (32'(nib) <= LAST);
        assign masked[d]  = io_addr[OFF_W-1:0] & MASK;
    end

    always_comb begin
        dev_off = '0;
        for (int d = 0; d < NIO; d++)
            if (dev_hit[d]) dev_off = masked[d];
    end
endmodule

// File: rtl/bank_noise_lfsr.sv
module bank_noise_lfsr
    import bank_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [LFSR_W-1:0] state_o
);
    logic [LFSR_W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (step) lfsr_d = {lfsr_q[LFSR_W-2:0], ^(lfsr_q & TAPS)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign state_o = lfsr_q;
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
    import bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic [NIB_W-1:0]  col_rdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic [NSEL-1:0]   chip_sel,
    output logic [OFF_W-1:0]  reg_off,
    output logic [NIB_W-1:0]  col_wdata
);
    localparam int PAGE_W = 4;

    logic [DATA_W-1:0] dir_q, val_q, eff;
    logic [LFSR_W-1:0] noise_q;
    logic [NIO-1:0]    dev_hit;
    logic [OFF_W-1:0]  dev_off;
    bank_map_t         map;
    logic              wr_dir, wr_val, port_hit, col_read;
    logic [PAGE_W-1:0] page;

    assign port_hit = (acc_addr[ADDR_W-1:1] == '0);
    assign wr_dir   = acc_valid && acc_we && port_hit && !acc_addr[0];
    assign wr_val   = acc_valid && acc_we && port_hit &&  acc_addr[0];
    assign page     = acc_addr[ADDR_W-1 -: PAGE_W];

    bank_port_regs u_port (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_dir(wr_dir),
        .wr_val(wr_val),
        .wdata (acc_wdata),
        .dir_o (dir_q),
        .val_o (val_q),
        .eff_o (eff)
    );

    bank_window_map u_map (
        .eff(eff),
        .map(map)
    );

    bank_io_select u_io (
        .io_addr(acc_addr[11:0]),
        .dev_hit(dev_hit),
        .dev_off(dev_off)
    );

    always_comb begin
        chip_sel = '0;
        reg_off  = '0;
        if (acc_valid) begin
            unique case (page)
                4'hA, 4'hB: begin
                    if (map.basic_vis && !acc_we) chip_sel[SEL_BASIC] = 1'b1;
                    else                          chip_sel[SEL_RAM]   = 1'b1;
                end
                4'hE, 4'hF: begin
                    if (map.kernal_vis && !acc_we) chip_sel[SEL_KERNAL] = 1'b1;
                    else                           chip_sel[SEL_RAM]    = 1'b1;
                end
                4'hD: begin
                    if (map.io_vis) begin
                        chip_sel[SEL_VIDEO +: NIO] = dev_hit;
                        reg_off                    = dev_off;
                    end else if (map.char_vis && !acc_we) begin
                        chip_sel[SEL_CHAR] = 1'b1;
                    end else begin
                        chip_sel[SEL_RAM] = 1'b1;
                    end
                end
                default: chip_sel[SEL_RAM] = 1'b1;
            endcase
        end
    end

    assign col_read = acc_valid && !acc_we && chip_sel[SEL_COLOUR];

    bank_noise_lfsr u_noise (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (col_read),
        .state_o(noise_q)
    );

    always_comb begin
        if (port_hit)      acc_rdata = acc_addr[0] ? val_q : dir_q;
        else if (col_read) acc_rdata = {noise_q[NIB_W-1:0], col_rdata};
        else               acc_rdata = ext_rdata;
    end

    assign col_wdata = acc_wdata[NIB_W-1:0];
endmodule

// File: rtl/bank_decoder_chk.sv
module bank_decoder_chk
    import bank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_we,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic [NIB_W-1:0]  col_rdata,
    input logic [DATA_W-1:0] acc_rdata,
    input logic [NSEL-1:0]   chip_sel,
    input logic [DATA_W-1:0] port_dir,
    input logic [DATA_W-1:0] port_val,
    input logic [LFSR_W-1:0] noise
);
    logic port_wr, col_rd;
    assign port_wr = acc_valid && acc_we && (acc_addr[ADDR_W-1:1] == '0);
    assign col_rd  = acc_valid && !acc_we && chip_sel[SEL_COLOUR];

    assert_one_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $countones(chip_sel) == 1);

    assert_idle_none_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> chip_sel == '0);

    assert_write_no_rom_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_we) |->
            !(chip_sel[SEL_BASIC] || chip_sel[SEL_KERNAL] || chip_sel[SEL_CHAR]));

    assert_port_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !port_wr |=> ($stable(port_dir) && $stable(port_val)));

    assert_sense_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> (port_dir[4] || port_val[4]));

    assert_colour_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        col_rd |-> acc_rdata[NIB_W-1:0] == col_rdata);

    assert_noise_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !col_rd |=> $stable(noise));

    assert_noise_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        noise != '0);
endmodule

bind bank_decoder bank_decoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_we   (acc_we),
    .acc_addr (acc_addr),
    .acc_wdata(acc_wdata),
    .col_rdata(col_rdata),
    .acc_rdata(acc_rdata),
    .chip_sel (chip_sel),
    .port_dir (dir_q),
    .port_val (val_q),
    .noise    (noise_q)
);

// File: tb/test_bank_decoder.sv
`timescale 1ns/1ps
module test_bank_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_we = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  ext_rdata = 8'h5A;
    logic [3:0]  col_rdata = '0;
    logic [7:0]  acc_rdata;
    logic [10:0] chip_sel;
    logic [9:0]  reg_off;
    logic [3:0]  col_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] model_noise = 16'hACE1;

    always #2.5 clk = ~clk;

    bank_decoder i_bank_decoder (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .ext_rdata(ext_rdata),
        .col_rdata(col_rdata), .acc_rdata(acc_rdata), .chip_sel(chip_sel),
        .reg_off(reg_off), .col_wdata(col_wdata)
    );

    typedef struct packed {
        logic [7:0]  dir;
        logic [7:0]  val;
        logic [15:0] addr;
        logic        we;
        logic [10:0] sel;
        logic [9:0]  off;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{8'hFF, 8'h07, 16'hA123, 1'b0, 11'h002, 10'h000}, // R2 basic
        '{8'hFF, 8'h06, 16'hA123, 1'b0, 11'h001, 10'h000}, // R2 low bit 0
        '{8'hFF, 8'h03, 16'hBFFF, 1'b0, 11'h002, 10'h000}, // R2 top edge
        '{8'hFF, 8'h07, 16'h9FFF, 1'b0, 11'h001, 10'h000}, // R2 below window
        '{8'hFF, 8'h05, 16'hE010, 1'b0, 11'h001, 10'h000}, // R3 hi bit 0
        '{8'hFF, 8'h02, 16'hFFFF, 1'b0, 11'h004, 10'h000}, // R3 kernal only
        '{8'hFF, 8'h07, 16'hD020, 1'b0, 11'h010, 10'h020}, // R4/R5 video
        '{8'hFF, 8'h05, 16'hD020, 1'b0, 11'h010, 10'h020}, // R4 io with 01
        '{8'hFF, 8'h03, 16'hD020, 1'b0, 11'h008, 10'h000}, // R4 char
        '{8'hFF, 8'h04, 16'hD020, 1'b0, 11'h001, 10'h000}, // R4 ram
        '{8'hFF, 8'h00, 16'hD020, 1'b0, 11'h001, 10'h000}, // R4 ram
        '{8'hFF, 8'h07, 16'hD3FF, 1'b0, 11'h010, 10'h03F}, // R5 video mirror
        '{8'hFF, 8'h07, 16'hD41F, 1'b0, 11'h020, 10'h01F}, // R5 sound
        '{8'hFF, 8'h07, 16'hD7FF, 1'b0, 11'h020, 10'h01F}, // R5 sound top
        '{8'hFF, 8'h07, 16'hD9AB, 1'b1, 11'h040, 10'h1AB}, // R5 colour
        '{8'hFF, 8'h07, 16'hDC0F, 1'b0, 11'h080, 10'h00F}, // R5 timer 1
        '{8'hFF, 8'h07, 16'hDD13, 1'b0, 11'h100, 10'h003}, // R5 timer 2
        '{8'hFF, 8'h07, 16'hDE80, 1'b0, 11'h200, 10'h080}, // R5 exp 1
        '{8'hFF, 8'h07, 16'hDFFF, 1'b0, 11'h400, 10'h0FF}, // R5 exp 2
        '{8'hFF, 8'h07, 16'hA000, 1'b1, 11'h001, 10'h000}, // R8 basic write
        '{8'hFF, 8'h07, 16'hE000, 1'b1, 11'h001, 10'h000}, // R8 kernal write
        '{8'hFF, 8'h03, 16'hD000, 1'b1, 11'h001, 10'h000}, // R8 char write
        '{8'hFF, 8'h07, 16'hD000, 1'b1, 11'h010, 10'h000}, // R8 io write
        '{8'hFF, 8'h07, 16'hCFFF, 1'b0, 11'h001, 10'h000}, // R2 plain ram
        '{8'h00, 8'h00, 16'hA000, 1'b0, 11'h002, 10'h000}, // R2 inputs high
        '{8'h00, 8'h00, 16'hF000, 1'b0, 11'h004, 10'h000}  // R3 inputs high
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(logic v, logic we, logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        acc_valid = v; acc_we = we; acc_addr = a; acc_wdata = d;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 16'h0000, 8'h00);
    endtask

    task automatic port_write(logic [15:0] a, logic [7:0] d);
        drive(1'b1, 1'b1, a, d);
        idle();
    endtask

    function automatic logic [15:0] step_noise(logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state read back through the port addresses
        drive(1'b1, 1'b0, 16'h0000, 8'h00);
        check("R1 dir after reset", acc_rdata, 8'h00);
        check("R1 ram select", chip_sel, 11'h001);
        drive(1'b1, 1'b0, 16'h0001, 8'h00);
        check("R1 val after reset", acc_rdata, 8'h00);
        // R11 idle gives no select
        idle();
        check("R11 idle select", chip_sel, 11'h000);

        // table walk
        for (int i = 0; i < NV; i++) begin
            port_write(16'h0000, VEC[i].dir);
            port_write(16'h0001, VEC[i].val);
            drive(1'b1, VEC[i].we, VEC[i].addr, 8'hC3);
            check($sformatf("vec %0d select", i), chip_sel, VEC[i].sel);
            check($sformatf("vec %0d offset", i), reg_off, VEC[i].off);
            idle();
        end

        // R10 sense bit forced while direction bit 4 is input
        port_write(16'h0000, 8'h00);
        drive(1'b1, 1'b0, 16'h0001, 8'h00);
        check("R10 forced by dir write", acc_rdata, 8'h10);
        port_write(16'h0000, 8'hFF);
        port_write(16'h0001, 8'h00);
        drive(1'b1, 1'b0, 16'h0001, 8'h00);
        check("R10 not forced as output", acc_rdata, 8'h00);
        port_write(16'h0000, 8'hEF);
        drive(1'b1, 1'b0, 16'h0001, 8'h00);
        check("R10 forced again", acc_rdata, 8'h10);
        drive(1'b1, 1'b0, 16'h0000, 8'h00);
        check("R9 dir read back", acc_rdata, 8'hEF);

        // R9 back-to-back: old map before edge, new map after
        port_write(16'h0000, 8'hFF);
        port_write(16'h0001, 8'h07);
        drive(1'b1, 1'b0, 16'hA000, 8'h00);
        check("R9 before write", chip_sel, 11'h002);
        drive(1'b1, 1'b1, 16'h0001, 8'h06);
        check("R9 write cycle ram", chip_sel, 11'h001);
        drive(1'b1, 1'b0, 16'hA000, 8'h00);
        check("R9 after write", chip_sel, 11'h001);
        drive(1'b1, 1'b0, 16'h0001, 8'h00);
        check("R9 val read back", acc_rdata, 8'h06);
        idle();

        // R11 ordinary read passes external data
        ext_rdata = 8'h3C;
        drive(1'b1, 1'b0, 16'h1234, 8'h00);
        check("R11 ext data", acc_rdata, 8'h3C);

        // R6/R7 colour reads back to back
        port_write(16'h0001, 8'h07);
        for (int k = 0; k < 6; k++) begin
            col_rdata = 4'(k * 3 + 1);
            drive(1'b1, 1'b0, 16'hD800 + 16'(k), 8'h00);
            check("R6 colour read", acc_rdata, {model_noise[3:0], 4'(k * 3 + 1)});
            model_noise = step_noise(model_noise);
        end
        // R7 non-colour accesses leave the noise untouched
        port_write(16'h0001, 8'h03);
        drive(1'b1, 1'b0, 16'hD800, 8'h00);
        check("R7 char not colour", chip_sel, 11'h008);
        port_write(16'h0001, 8'h07);
        drive(1'b1, 1'b1, 16'hD805, 8'hF5);
        check("R6 colour write nibble", col_wdata, 4'h5);
        col_rdata = 4'h9;
        drive(1'b1, 1'b0, 16'hDBFF, 8'h00);
        check("R7 noise held", acc_rdata, {model_noise[3:0], 4'h9});
        check("R5 colour offset", reg_off, 10'h3FF);
        idle();

        finish_run();
    end
endmodule